// File: doc/BRIEF.md
# Boot Memory Remap Decoder

This block sits at the bottom of a processor memory map and picks which memory answers an access to the boot window. The boot window is the lowest 256 KB. After reset a strap switch decides whether boot ROM or flash serves it. Once start-up code has set up RAM, it sets a one-bit remap control and the same window then selects RAM. The remap control only works when an active-low board-present strap is low. With that strap high, the window always decodes as if remap were clear.

The chip-select logic is purely combinational from the address, the access strobe and the control state. The only clocked element is the remap bit. It is written and read back on data bit 0 through a register-select strobe.

A second build variant, chosen by the `LOGIC_MODE` parameter, serves a secondary module. In that variant the whole bottom 256 MB goes either to an external bus (switch on) or to flash (switch off), and the remap bit has no effect. Flash is aliased through that region because only the low address bits that span the flash are passed on to it.

Top module: `bootRemapDecoder`

## Requirements
- R1: After the synchronous active-low reset, the remap bit is 0 and the whole `remapRead` bus reads 0.
- R2: On a clock edge with `regSel` and `regWrite` both high, the remap bit takes `regWrData[0]`, and `remapRead[0]` shows it from the next cycle. All other `remapRead` bits stay 0. A cycle with `regSel` high and `regWrite` low leaves the bit unchanged.
- R3: Base variant: with the effective remap clear, an access to byte addresses 0x00000000..0x0003FFFF with `bootSwitchOn`=1 asserts `romSel`.
- R4: Base variant: with the effective remap clear and `bootSwitchOn`=0, an access to the window asserts `flashSel`.
- R5: Base variant: with the remap bit 1 and `boardPresentN`=0, an access to the window asserts `ramSel`, whatever the switch.
- R6: With `boardPresentN`=1, the window decodes as if remap were 0 even when the remap bit is 1.
- R7: No chip select is asserted while `accessValid` is 0.
- R8: At most one of `romSel`, `flashSel`, `ramSel` and `extSel` is high. Exactly one is high for a valid access inside the decoded region.
- R9: Base variant: addresses at 0x00040000 and above assert no chip select, and `extSel` is never asserted.
- R10: Secondary variant (`LOGIC_MODE`=1): a valid access below 0x10000000 asserts `extSel` when `bootSwitchOn`=1 and `flashSel` when it is 0. Addresses at 0x10000000 and above assert nothing.
- R11: `flashAddr` equals the access address modulo 2^`FLASH_AW`, so flash repeats across the region.
- R12: Chip selects follow address, strobe and straps in the same cycle. A remap write changes the decode from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| addr | input | AW | Byte address of the access |
| accessValid | input | 1 | Access strobe |
| regSel | input | 1 | Remap register select |
| regWrite | input | 1 | Write enable for the remap register |
| regWrData | input | DW | Write data; bit 0 is the remap value |
| bootSwitchOn | input | 1 | Boot-select switch (1 = on) |
| boardPresentN | input | 1 | Board-present strap, active low |
| romSel | output | 1 | Boot ROM chip select |
| flashSel | output | 1 | Flash chip select |
| ramSel | output | 1 | RAM chip select |
| extSel | output | 1 | External bus chip select (secondary variant) |
| flashAddr | output | FLASH_AW | Low address bits passed to flash |
| remapRead | output | DW | Readback of the remap register on bit 0 |

## Verification
A remap write and a window access can fall in the same cycle. The decode for that access must still use the old remap value, and the new value must take over only on the next cycle. The bench provokes this by holding a valid window access while it pulses a register write. It checks the chip select before the edge against the old remap state and after the edge against the new one. A strap change coinciding with a remapped access is swept exhaustively in the same way.

// File: rtl/remapPkg.sv
package remapPkg;
  // Strobes handed from the control half to the decode half
  typedef struct packed {
    logic remapActive;   // remap bit set and honoured by the board strap
    logic bootFromRom;   // boot switch selects ROM (or external bus)
  } ctrlStrobes_t;
endpackage

// File: rtl/remapCtrl.sv
module remapCtrl
  import remapPkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regSel,
  input  logic          regWrite,
  input  logic [DW-1:0] regWrData,
  input  logic          bootSwitchOn,
  input  logic          boardPresentN,
  output ctrlStrobes_t  strobes,
  output logic [DW-1:0] remapRead
);
  logic remapBit;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[DW-1:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remapBit <= 1'b0;
    end else if (regSel && regWrite) begin
      remapBit <= regWrData[0];
    end
  end

  always_comb begin
    strobes.remapActive = remapBit & ~boardPresentN;
    strobes.bootFromRom = bootSwitchOn;
    remapRead           = '0;
    remapRead[0]        = remapBit;
  end
endmodule

// File: rtl/remapDecode.sv
module remapDecode
  import remapPkg::*;
#(
  parameter int AW         = 32,
  parameter int WINDOW_AW  = 18,
  parameter int REGION_AW  = 28,
  parameter int FLASH_AW   = 22,
  parameter bit LOGIC_MODE = 1'b0
) (
  input  logic [AW-1:0]       addr,
  input  logic                accessValid,
  input  ctrlStrobes_t        strobes,
  output logic                romSel,
  output logic                flashSel,
  output logic                ramSel,
  output logic                extSel,
  output logic [FLASH_AW-1:0] flashAddr
);
  localparam int WIN_TOP_W = AW - WINDOW_AW;
  localparam int REG_TOP_W = AW - REGION_AW;

  assign flashAddr = addr[FLASH_AW-1:0];

  generate
    if (LOGIC_MODE) begin : gSecondary
      logic inRegion;
      logic unusedRemap;
      assign unusedRemap = strobes.remapActive;
      assign inRegion = (addr[AW-1:REGION_AW] == {REG_TOP_W{1'b0}});
      always_comb begin
        romSel   = 1'b0;
        ramSel   = 1'b0;
        extSel   = accessValid & inRegion & strobes.bootFromRom;
        flashSel = accessValid & inRegion & ~strobes.bootFromRom;
      end
    end else begin : gBase
      logic inWindow;
      assign inWindow = (addr[AW-1:WINDOW_AW] == {WIN_TOP_W{1'b0}});
      always_comb begin
        romSel   = 1'b0;
        flashSel = 1'b0;
        ramSel   = 1'b0;
        extSel   = 1'b0;
        if (accessValid && inWindow) begin
          if (strobes.remapActive)      ramSel   = 1'b1;
          else if (strobes.bootFromRom) romSel   = 1'b1;
          else                          flashSel = 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bootRemapDecoder.sv
module bootRemapDecoder
  import remapPkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int WINDOW_AW  = 18,
  parameter int REGION_AW  = 28,
  parameter int FLASH_AW   = 22,
  parameter bit LOGIC_MODE = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [AW-1:0]       addr,
  input  logic                accessValid,
  input  logic                regSel,
  input  logic                regWrite,
  input  logic [DW-1:0]       regWrData,
  input  logic                bootSwitchOn,
  input  logic                boardPresentN,
  output logic                romSel,
  output logic                flashSel,
  output logic                ramSel,
  output logic                extSel,
  output logic [FLASH_AW-1:0] flashAddr,
  output logic [DW-1:0]       remapRead
);
  ctrlStrobes_t strobes;

  remapCtrl #(.DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regWrData(regWrData), .bootSwitchOn(bootSwitchOn),
    .boardPresentN(boardPresentN), .strobes(strobes), .remapRead(remapRead)
  );

  remapDecode #(
    .AW(AW), .WINDOW_AW(WINDOW_AW), .REGION_AW(REGION_AW),
    .FLASH_AW(FLASH_AW), .LOGIC_MODE(LOGIC_MODE)
  ) uDecode (
    .addr(addr), .accessValid(accessValid), .strobes(strobes),
    .romSel(romSel), .flashSel(flashSel), .ramSel(ramSel),
    .extSel(extSel), .flashAddr(flashAddr)
  );
endmodule

// File: rtl/remapChecker.sv
module remapChecker #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int WINDOW_AW  = 18,
  parameter bit LOGIC_MODE = 1'b0
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] addr,
  input logic          accessValid,
  input logic          regSel,
  input logic          regWrite,
  input logic [DW-1:0] regWrData,
  input logic          boardPresentN,
  input logic          romSel,
  input logic          flashSel,
  input logic          ramSel,
  input logic          extSel,
  input logic [DW-1:0] remapRead
);
  logic inWin;
  assign inWin = (addr < (AW'(1) << WINDOW_AW));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (remapRead == '0));

  assert_write_takes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWrite) |=> (remapRead[0] == $past(regWrData[0])));

  assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(regSel && regWrite) |=> $stable(remapRead));

  assert_ram_needs_remap_R5: assert property (@(posedge clk) disable iff (!rstN)
    ramSel |-> (remapRead[0] && !boardPresentN));

  assert_strap_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    boardPresentN |-> !ramSel);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !accessValid |-> !(romSel || flashSel || ramSel || extSel));

  assert_one_select_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({romSel, flashSel, ramSel, extSel}));

  generate
    if (!LOGIC_MODE) begin : gBaseChk
      assert_outside_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
        !inWin |-> !(romSel || flashSel || ramSel || extSel));
    end
  endgenerate
endmodule

bind bootRemapDecoder remapChecker #(
  .AW(AW), .DW(DW), .WINDOW_AW(WINDOW_AW), .LOGIC_MODE(LOGIC_MODE)
) uRemapChecker (
  .clk(clk), .rstN(rstN), .addr(addr), .accessValid(accessValid),
  .regSel(regSel), .regWrite(regWrite), .regWrData(regWrData),
  .boardPresentN(boardPresentN), .romSel(romSel), .flashSel(flashSel),
  .ramSel(ramSel), .extSel(extSel), .remapRead(remapRead)
);

// File: tb/test_bootRemapDecoder.sv
module test_bootRemapDecoder;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int FAW = 22;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic accessValid = 1'b0, regSel = 1'b0, regWrite = 1'b0;
  logic [DW-1:0] regWrData = '0;
  logic bootSwitchOn = 1'b0, boardPresentN = 1'b0;
  logic romSel, flashSel, ramSel, extSel;
  logic [FAW-1:0] flashAddr;
  logic [DW-1:0] remapRead;
  logic aRom, aFlash, aRam, aExt;
  logic [FAW-1:0] aFlashAddr;
  logic [DW-1:0] aRead;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bootRemapDecoder #(.AW(AW), .DW(DW), .FLASH_AW(FAW)) i_bootRemapDecoder (
    .clk(clk), .rstN(rstN), .addr(addr), .accessValid(accessValid),
    .regSel(regSel), .regWrite(regWrite), .regWrData(regWrData),
    .bootSwitchOn(bootSwitchOn), .boardPresentN(boardPresentN),
    .romSel(romSel), .flashSel(flashSel), .ramSel(ramSel), .extSel(extSel),
    .flashAddr(flashAddr), .remapRead(remapRead));

  bootRemapDecoder #(.AW(AW), .DW(DW), .FLASH_AW(FAW), .LOGIC_MODE(1'b1)) i_bootRemapDecoderAlt (
    .clk(clk), .rstN(rstN), .addr(addr), .accessValid(accessValid),
    .regSel(regSel), .regWrite(regWrite), .regWrData(regWrData),
    .bootSwitchOn(bootSwitchOn), .boardPresentN(boardPresentN),
    .romSel(aRom), .flashSel(aFlash), .ramSel(aRam), .extSel(aExt),
    .flashAddr(aFlashAddr), .remapRead(aRead));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (addr %h)", req, act, exp, addr);
    end
  endtask

  // Remap register write, finished at the following negedge
  task automatic writeRemap(input logic val, input logic doWrite);
    @(negedge clk);
    regSel = 1'b1; regWrite = doWrite; regWrData = {{(DW-1){1'b1}}, val};
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0; regWrData = '0;
  endtask

  // Arithmetic model of the base decode, returns {rom,flash,ram,ext}
  function automatic logic [3:0] expBase(input logic [AW-1:0] a, input logic v,
      input logic rm, input logic bpN, input logic sw);
    if (!v || a >= 32'h0004_0000) return 4'b0000;
    if (rm && !bpN) return 4'b0010;
    return sw ? 4'b1000 : 4'b0100;
  endfunction

  function automatic logic [3:0] expAlt(input logic [AW-1:0] a, input logic v, input logic sw);
    if (!v || a >= 32'h1000_0000) return 4'b0000;
    return sw ? 4'b0001 : 4'b0100;
  endfunction

  logic [AW-1:0] addrList [10] = '{32'h0, 32'h4, 32'h0002_1230, 32'h0003_FFFF,
    32'h0004_0000, 32'h0040_0010, 32'h0FFF_FFFF, 32'h1000_0000,
    32'h8000_0000, 32'hFFFF_FFFF};

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // Write attempt during reset must be overridden (R1)
    regSel = 1'b1; regWrite = 1'b1; regWrData = 32'h1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0; regWrData = '0;
    check("R1", remapRead, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", remapRead, '0);

    // R2: write without regWrite ignored; write sets bit 0 only
    writeRemap(1'b1, 1'b0);
    check("R2", remapRead, '0);
    writeRemap(1'b1, 1'b1);
    check("R2", remapRead, 64'h1);
    writeRemap(1'b0, 1'b1);
    check("R2", remapRead, '0);

    // Exhaustive sweep: R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int rm = 0; rm < 2; rm++) begin
      writeRemap(rm[0], 1'b1);
      check("R2", remapRead, 64'(rm));
      for (int k = 0; k < 10; k++) begin
        for (int s = 0; s < 8; s++) begin
          @(negedge clk);
          addr = addrList[k];
          accessValid = s[0]; bootSwitchOn = s[1]; boardPresentN = s[2];
          #2;
          check("R3/R4/R5/R6/R7/R8/R9", {romSel, flashSel, ramSel, extSel},
                expBase(addr, s[0], rm[0], s[2], s[1]));
          check("R10", {aRom, aFlash, aRam, aExt}, expAlt(addr, s[0], s[1]));
          check("R11", flashAddr, addr % (32'h1 << FAW));
          check("R11", aFlashAddr, addr % (32'h1 << FAW));
        end
      end
    end

    // R12: write in the same cycle as a window access; old value first
    writeRemap(1'b0, 1'b1);
    @(negedge clk);
    addr = 32'h100; accessValid = 1'b1; bootSwitchOn = 1'b1; boardPresentN = 1'b0;
    regSel = 1'b1; regWrite = 1'b1; regWrData = 32'h1;
    #2;
    check("R12", {romSel, ramSel}, 2'b10);
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0;
    #2;
    check("R12", {romSel, ramSel}, 2'b01);
    // R6: strap change in the same cycle redirects back to ROM
    boardPresentN = 1'b1;
    #1;
    check("R6", {romSel, ramSel}, 2'b10);
    accessValid = 1'b0;
    #1;
    check("R7", {romSel, flashSel, ramSel, extSel}, 4'b0000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule